// File: doc/BRIEF.md
# I2C Byte-Event Wait and Interrupt Timing Controller

This block sits next to an I2C shift engine that runs as either bus master or slave. On each byte it decides whether a byte-event interrupt is raised, and on which falling edge of SCL. That edge is the eighth or the ninth clock of the byte. On the same edge it may also start a wait, which holds SCL low. The shift engine supplies:

- the index of the clock now on the bus;
- whether the byte is an address byte;
- the address-match, extension-code and repeated-start flags.

Software supplies a timing select bit, an ACK enable bit and four release actions.

SCL is brought into the system clock domain through a synchronizer, and its falling edges are detected there. When an event fires, the interrupt is a single system-clock pulse. When a wait is chosen, the SCL-hold request rises together with that pulse. The hold stays high until software performs any one of its release actions. At that release, the controller also latches the ACK enable bit as the ACK decision for the engine.

Top module: `i2c_wait_ctl`

## Requirements
- R1: The block acts only on a high-to-low transition of the synchronized SCL. The irq output rises exactly 3 system clock edges after scl_in is first seen low (two synchronizer stages plus one output register) and lasts exactly one cycle. A rising SCL edge produces nothing.
- R2: For a data byte (addr_phase=0), wait_sel=0 places the interrupt and wait on clock 8 (bit_idx=8), and wait_sel=1 places them on clock 9 (bit_idx=9). The other clock index gives no event.
- R3: For an address byte with is_master=1, the interrupt and wait occur on clock 9 only, whatever the value of wait_sel.
- R4: For a slave address byte with addr_match=1, the interrupt and wait occur on clock 9 and not on clock 8.
- R5: For a slave address byte that carries an extension code (ext_code=1, addr_match=0), the interrupt and wait occur on clock 8 and not on clock 9.
- R6: For a slave address byte that neither matches nor carries an extension code, and that does not follow a repeated start, neither an interrupt nor a wait occurs.
- R7: For a slave address byte that follows a repeated start (restart=1) and does not match, an interrupt occurs on clock 9 with scl_hold staying low.
- R8: Once raised, scl_hold stays high until a cycle in which any of wr_data, wr_rel, start_req or stop_req is high. It is low after that edge. Several release actions in one cycle act as a single release.
- R9: ack_out takes the value of ack_en at the release edge and keeps it until the next release. Changes to ack_en at other times do not affect it.
- R10: A release action while scl_hold is low has no effect on scl_hold or ack_out.
- R11: After reset, irq, scl_hold and ack_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| bit_idx | input | 4 | Index (1..9) of the SCL clock currently on the bus in this byte |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| addr_phase | input | 1 | 1 = current byte is an address byte |
| addr_match | input | 1 | Slave: received address equals own address |
| ext_code | input | 1 | Slave: received address is an extension code |
| restart | input | 1 | Current byte follows a repeated start |
| wait_sel | input | 1 | Data-byte timing: 0 = clock 8, 1 = clock 9 |
| ack_en | input | 1 | Software ACK enable, latched at release |
| wr_data | input | 1 | Release: shift register written |
| wr_rel | input | 1 | Release: wait-release bit set |
| start_req | input | 1 | Release: start condition requested |
| stop_req | input | 1 | Release: stop condition requested |
| scl_hold | output | 1 | Request to hold SCL low (wait) |
| irq | output | 1 | One-cycle byte-event interrupt pulse |
| ack_out | output | 1 | ACK decision latched at release |

## Verification
The hardest case to reach from the ports is a slave address byte after a repeated start that does not match. In that case the interrupt must fire while the hold stays low. The stimulus sets restart with both match flags clear, drops SCL at clock 9 and checks irq and scl_hold in the same sampling cycle. It also checks that clock 8 of that byte stays silent. A second hard case is release timing: the bench issues all four release actions at once, and changes ack_en both before and after the release edge, so that the latched ACK is seen to come only from the release cycle.

// File: rtl/i2c_wt_pkg.sv
package i2c_wt_pkg;

    localparam int IDX_W    = 4;
    localparam int EARLY_CK = 8;
    localparam int LATE_CK  = 9;

    typedef struct packed {
        logic master;
        logic addr_ph;
        logic match;
        logic ext;
        logic restart;
        logic sel;
    } ctx_t;

    typedef struct packed {
        logic fire;
        logic stall;
    } evt_t;

    function automatic evt_t decide(ctx_t c, logic at8, logic at9);
        evt_t e;
        e = '{fire: 1'b0, stall: 1'b0};
        if (!c.addr_ph) begin
            if ((c.sel && at9) || (!c.sel && at8)) e = '{fire: 1'b1, stall: 1'b1};
        end else if (c.master) begin
            if (at9) e = '{fire: 1'b1, stall: 1'b1};
        end else if (c.match) begin
            if (at9) e = '{fire: 1'b1, stall: 1'b1};
        end else if (c.ext) begin
            if (at8) e = '{fire: 1'b1, stall: 1'b1};
        end else if (c.restart) begin
            if (at9) e = '{fire: 1'b1, stall: 1'b0};
        end
        return e;
    endfunction

endpackage

// File: rtl/scl_fall_det.sv
module scl_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= 1'b1;
                else     sh <= scl_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-2:0], scl_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= sh[STAGES-1];
    end

    assign fall = prev && !sh[STAGES-1];

    // R1
    fall_single_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
endmodule

// File: rtl/evt_decode.sv
module evt_decode
    import i2c_wt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fall,
    input  logic [IDX_W-1:0] bit_idx,
    input  ctx_t             ctx,
    output evt_t             evt
);
    logic at8, at9;
    evt_t raw;

    assign at8 = (bit_idx == IDX_W'(EARLY_CK));
    assign at9 = (bit_idx == IDX_W'(LATE_CK));

    always_comb begin
        raw = decide(ctx, at8, at9);
        evt = fall ? raw : '{fire: 1'b0, stall: 1'b0};
    end

    // R7
    stall_needs_fire_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stall |-> evt.fire);
    // R6
    silent_slave_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx.addr_ph && !ctx.master && !ctx.match && !ctx.ext && !ctx.restart) |-> !evt.fire);
endmodule

// File: rtl/wait_hold.sv
module wait_hold
    import i2c_wt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    input  logic rel,
    input  logic ack_en,
    output logic scl_hold,
    output logic irq,
    output logic ack_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_hold <= 1'b0;
            irq      <= 1'b0;
            ack_out  <= 1'b0;
        end else begin
            irq <= evt.fire;
            if (scl_hold && rel) ack_out <= ack_en;
            if (evt.stall)       scl_hold <= 1'b1;
            else if (rel)        scl_hold <= 1'b0;
        end
    end

    // R1
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    // R8
    hold_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_hold && !rel) |=> scl_hold);
    // R8
    hold_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_hold) |-> irq);
    // R9
    ack_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(scl_hold && rel) |=> $stable(ack_out));
endmodule

// File: rtl/i2c_wait_ctl.sv
module i2c_wait_ctl
    import i2c_wt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             is_master,
    input  logic             addr_phase,
    input  logic             addr_match,
    input  logic             ext_code,
    input  logic             restart,
    input  logic             wait_sel,
    input  logic             ack_en,
    input  logic             wr_data,
    input  logic             wr_rel,
    input  logic             start_req,
    input  logic             stop_req,
    output logic             scl_hold,
    output logic             irq,
    output logic             ack_out
);
    logic fall;
    logic rel;
    ctx_t ctx;
    evt_t evt;

    assign rel = wr_data | wr_rel | start_req | stop_req;
    assign ctx = '{master: is_master, addr_ph: addr_phase, match: addr_match,
                   ext: ext_code, restart: restart, sel: wait_sel};

    scl_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
        .clk(clk), .rst(rst), .scl_in(scl_in), .fall(fall)
    );

    evt_decode u_dec (
        .clk(clk), .rst(rst), .fall(fall), .bit_idx(bit_idx), .ctx(ctx), .evt(evt)
    );

    wait_hold u_hold (
        .clk(clk), .rst(rst), .evt(evt), .rel(rel), .ack_en(ack_en),
        .scl_hold(scl_hold), .irq(irq), .ack_out(ack_out)
    );
endmodule

// File: tb/sim_i2c_wait_ctl.sv
module sim_i2c_wait_ctl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_in = 1'b1;
    logic [3:0] bit_idx = 4'd0;
    logic is_master = 1'b0, addr_phase = 1'b0, addr_match = 1'b0, ext_code = 1'b0;
    logic restart = 1'b0, wait_sel = 1'b0, ack_en = 1'b0;
    logic wr_data = 1'b0, wr_rel = 1'b0, start_req = 1'b0, stop_req = 1'b0;
    logic scl_hold, irq, ack_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_wait_ctl u0 (
        .clk(clk), .rst(rst), .scl_in(scl_in), .bit_idx(bit_idx),
        .is_master(is_master), .addr_phase(addr_phase), .addr_match(addr_match),
        .ext_code(ext_code), .restart(restart), .wait_sel(wait_sel), .ack_en(ack_en),
        .wr_data(wr_data), .wr_rel(wr_rel), .start_req(start_req), .stop_req(stop_req),
        .scl_hold(scl_hold), .irq(irq), .ack_out(ack_out)
    );

    // {master, addr, match, ext, restart, sel, bit_idx[3:0], exp_irq, exp_hold}
    localparam logic [11:0] VEC [16] = '{
        {6'b000000, 4'd8, 2'b11},  // R2 data sel0 ck8
        {6'b000000, 4'd9, 2'b00},  // R2 data sel0 ck9
        {6'b000001, 4'd8, 2'b00},  // R2 data sel1 ck8
        {6'b000001, 4'd9, 2'b11},  // R2 data sel1 ck9
        {6'b110000, 4'd8, 2'b00},  // R3 master addr ck8
        {6'b110000, 4'd9, 2'b11},  // R3 master addr ck9
        {6'b110001, 4'd9, 2'b11},  // R3 master addr sel1 ck9
        {6'b011000, 4'd9, 2'b11},  // R4 slave match ck9
        {6'b011001, 4'd8, 2'b00},  // R4 slave match ck8
        {6'b010100, 4'd8, 2'b11},  // R5 ext ck8
        {6'b010100, 4'd9, 2'b00},  // R5 ext ck9
        {6'b010000, 4'd9, 2'b00},  // R6 no match ck9
        {6'b010000, 4'd8, 2'b00},  // R6 no match ck8
        {6'b010010, 4'd9, 2'b10},  // R7 restart mismatch ck9
        {6'b010010, 4'd8, 2'b00},  // R7 restart mismatch ck8
        {6'b000000, 4'd5, 2'b00}   // R2 other clock index
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drop_scl();
        @(negedge clk) scl_in = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic raise_scl();
        @(negedge clk) scl_in = 1'b1;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic pulse_rel(input logic [3:0] which);
        @(negedge clk) {wr_data, wr_rel, start_req, stop_req} = which;
        @(posedge clk); #1;
        @(negedge clk) {wr_data, wr_rel, start_req, stop_req} = 4'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk(irq == 0 && scl_hold == 0 && ack_out == 0, "R11", {irq, scl_hold, ack_out}, 0);
        @(negedge clk) rst = 1'b0;
        repeat (2) @(posedge clk);

        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            {is_master, addr_phase, addr_match, ext_code, restart, wait_sel} = VEC[i][11:6];
            bit_idx = VEC[i][5:2];
            drop_scl();
            chk(irq == VEC[i][1], $sformatf("R2-7 vec%0d irq", i), irq, VEC[i][1]);
            chk(scl_hold == VEC[i][0], $sformatf("R2-7 vec%0d hold", i), scl_hold, VEC[i][0]);
            @(posedge clk); #1;
            chk(irq == 0, "R1 pulse width", irq, 0);
            raise_scl();
            chk(irq == 0, "R1 rising edge silent", irq, 0);
            if (scl_hold) begin
                pulse_rel(4'b0100);
                chk(scl_hold == 0, "R8 wr_rel release", scl_hold, 0);
            end
        end

        // R1 latency: no irq after 2 edges, irq after 3
        @(negedge clk);
        {is_master, addr_phase, addr_match, ext_code, restart, wait_sel} = 6'b0;
        bit_idx = 4'd8;
        @(negedge clk) scl_in = 1'b0;
        repeat (2) @(posedge clk); #1;
        chk(irq == 0, "R1 early", irq, 0);
        @(posedge clk); #1;
        chk(irq == 1, "R1 latency", irq, 1);
        raise_scl();

        // R8 each release action, hold persists before it
        for (int k = 0; k < 4; k++) begin
            drop_scl();
            raise_scl();
            repeat (5) @(posedge clk); #1;
            chk(scl_hold == 1, "R8 hold persists", scl_hold, 1);
            pulse_rel(4'b1000 >> k);
            chk(scl_hold == 0, $sformatf("R8 release action %0d", k), scl_hold, 0);
        end

        // R8 simultaneous releases, R9 ack latch
        @(negedge clk) ack_en = 1'b1;
        drop_scl();
        raise_scl();
        pulse_rel(4'b1111);
        chk(scl_hold == 0, "R8 combined release", scl_hold, 0);
        chk(ack_out == 1, "R9 ack latched", ack_out, 1);
        @(negedge clk) ack_en = 1'b0;
        repeat (3) @(posedge clk); #1;
        chk(ack_out == 1, "R9 ack held", ack_out, 1);

        // R10 release with no hold
        pulse_rel(4'b0100);
        chk(ack_out == 1 && scl_hold == 0, "R10 idle release", {ack_out, scl_hold}, 2);

        // R9 ack_en changed before release
        drop_scl();
        raise_scl();
        @(negedge clk) ack_en = 1'b1;
        @(negedge clk) ack_en = 1'b0;
        pulse_rel(4'b0001);
        chk(ack_out == 0, "R9 ack at release", ack_out, 0);

        // R11 reset clears hold
        drop_scl();
        raise_scl();
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        chk(scl_hold == 0 && irq == 0, "R11 reset clears", {scl_hold, irq}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule